// File: doc/BRIEF.md
# Host Command Queue and Counted Block Transfer Port

This block is the host-facing port of an optical-disc buffer controller. It does two things. First, it takes command bytes from the host into a small first-in first-out queue. Each byte the queue accepts raises an interrupt toward the local control processor. The processor then pops the bytes one at a time. The block never decodes them; they leave exactly as they arrived.

Second, it moves data from buffer RAM out to the host. The processor presents a byte count and a start address, then pulses a start input. The block pulls the host-facing enable low and prefetches one byte from RAM. It hands that byte over on each host read strobe. If the host strobes before the next byte is ready, the block holds the host off with an active-low wait. When the last counted byte has been taken, the enable returns high and a completion interrupt pulses.

The transfer controller has four states. X_IDLE leaves on *arm* (start with a non-zero count) to X_FETCH. X_FETCH issues a RAM read. On *fill* (RAM acknowledge) it goes to X_READY if the host strobe is high, or straight to X_SERVE if the strobe is already low. X_READY goes to X_SERVE on *strobe*, which is the host read strobe going low. X_SERVE leaves on *release*, when the strobe returns high. Release leads to X_FETCH if bytes remain, or to X_IDLE on *finish* after the last byte.

Top module: `hostxfer_port`

## Requirements
- R1: After reset the queue is empty (`cmd_count`=0, `cmd_empty`=1), `cmd_ovf`=0, `cmd_irq`=0, `done_irq`=0, `xfer_en_n`=1, `wait_n`=1 and `ram_rd`=0.
- R2: Each falling edge of `host_wr_n` with fewer than 8 bytes queued stores `host_wdata`. `cmd_count` rises by one. `cmd_data` always shows the oldest queued byte.
- R3: Each accepted host write makes `cmd_irq` high for exactly one cycle, in the cycle after the strobe is sampled low.
- R4: A host write while 8 bytes are queued is ignored: count and contents are unchanged and no `cmd_irq` is raised. It also sets `cmd_ovf`, which stays set until reset.
- R5: A one-cycle `cmd_pop` removes the oldest byte, and bytes leave in arrival order with their values unchanged. A pop on an empty queue has no effect.
- R6: A `cpu_start` pulse in idle with non-zero `cpu_len` drives `xfer_en_n` low from the next cycle. A RAM read is issued at `cpu_addr`.
- R7: The n-th host read strobe of a transfer receives the RAM byte at start address + n−1 on `host_rdata`. The address is 16 bits and wraps from 0xFFFF to 0x0000.
- R8: `wait_n` is low exactly while `host_rd_n` is low and the next byte has not yet arrived from RAM. When the byte is already prefetched before the strobe, `wait_n` stays high.
- R9: When the host releases the strobe of the last counted byte, `xfer_en_n` returns high in the next cycle. `done_irq` is high for that one cycle only.
- R10: `cpu_start` during a transfer is ignored. `cpu_start` with `cpu_len`=0 gives a one-cycle `done_irq` in the next cycle and leaves `xfer_en_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_n | input | 1 | Host command write strobe, active low |
| host_wdata | input | 8 | Host command byte |
| host_rd_n | input | 1 | Host data read strobe, active low |
| host_rdata | output | 8 | Data byte to host |
| xfer_en_n | output | 1 | Transfer enable to host, active low |
| wait_n | output | 1 | Host wait request, active low |
| cmd_pop | input | 1 | Processor pops oldest command byte |
| cmd_data | output | 8 | Oldest queued command byte |
| cmd_count | output | 4 | Number of queued bytes |
| cmd_empty | output | 1 | Queue empty |
| cmd_ovf | output | 1 | Sticky overflow flag |
| cmd_irq | output | 1 | Command interrupt pulse |
| cpu_start | input | 1 | Transfer start trigger |
| cpu_len | input | 16 | Byte count to transfer |
| cpu_addr | input | 16 | Buffer RAM start address |
| done_irq | output | 1 | Transfer-complete interrupt pulse |
| ram_rd | output | 1 | Buffer RAM read request |
| ram_addr | output | 16 | Buffer RAM address |
| ram_rdata | input | 8 | Buffer RAM read data |
| ram_ack | input | 1 | RAM read data valid |

## Verification
Two things are hard to reach from the ports.

The first is the X_FETCH-to-X_SERVE shortcut, where a strobe arrives before the prefetch has completed. The bench reaches it by re-striking the read strobe one cycle after each release, against a RAM model with a selectable acknowledge latency. With latency three, wait stays low for several cycles on every byte.

The second is the opposite path, where the prefetch wins. A second run inserts idle cycles before each strobe so the byte is already waiting in X_READY.

Address wrap is reached by starting a transfer two bytes below the top of the address space.

// File: rtl/hxp_pkg.sv
package hxp_pkg;
    typedef enum logic [1:0] {
        X_IDLE  = 2'd0,
        X_FETCH = 2'd1,
        X_READY = 2'd2,
        X_SERVE = 2'd3
    } xfer_state_t;
endpackage

// File: rtl/hxp_fall_det.sv
module hxp_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= strobe_n;
    end

    assign fall = prev_q & ~strobe_n;
endmodule

// File: rtl/hxp_cmd_fifo.sv
module hxp_cmd_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          ovf,
    output logic          irq
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;
    logic          ovf_q, irq_q;
    logic          full, push_ok, pop_ok;

    assign full    = (count_q == CW'(DEPTH));
    assign push_ok = push & ~full;
    assign pop_ok  = pop & (count_q != '0);

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (push_ok) wr_q <= bump(wr_q);
            if (pop_ok)  rd_q <= bump(rd_q);
            if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
            else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
            ovf_q <= ovf_q | (push & full);
            irq_q <= push_ok;
        end
    end

    assign head  = mem_q[rd_q];
    assign count = count_q;
    assign empty = (count_q == '0);
    assign ovf   = ovf_q;
    assign irq   = irq_q;

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count_q == CW'(DEPTH) && ovf_q && !irq_q));
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q <= CW'(DEPTH)));
    assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count_q == '0 && !push) |=> (count_q == '0));
endmodule

// File: rtl/hxp_xfer_fsm.sv
module hxp_xfer_fsm
    import hxp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              rd_n,
    output logic [W-1:0]      rd_data,
    output logic              en_n,
    output logic              wait_n,
    output logic              done_irq,
    output logic              ram_rd,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [W-1:0]      ram_rdata,
    input  logic              ram_ack
);
    xfer_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [W-1:0]      data_q;
    logic              done_q;
    logic              last;

    assign last = (remain_q == LEN_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= X_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            X_IDLE:  if (start && len_in != '0) state_d = X_FETCH;
            X_FETCH: if (ram_ack)               state_d = rd_n ? X_READY : X_SERVE;
            X_READY: if (!rd_n)                 state_d = X_SERVE;
            X_SERVE: if (rd_n)                  state_d = last ? X_IDLE : X_FETCH;
            default:                            state_d = X_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            data_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                X_IDLE: if (start) begin
                    addr_q   <= addr_in;
                    remain_q <= len_in;
                    done_q   <= (len_in == '0);
                end
                X_FETCH: if (ram_ack) begin
                    data_q <= ram_rdata;
                    addr_q <= addr_q + 1'b1;
                end
                X_SERVE: if (rd_n) begin
                    remain_q <= remain_q - 1'b1;
                    done_q   <= last;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        en_n     = (state_q == X_IDLE);
        ram_rd   = (state_q == X_FETCH);
        wait_n   = ~((state_q == X_FETCH) && !rd_n);
        ram_addr = addr_q;
        rd_data  = data_q;
        done_irq = done_q;
    end

    assert_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && en_n && len_in != '0) |=> (!en_n && ram_rd && ram_addr == $past(addr_in)));
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd && ram_ack) |=> (rd_data == $past(ram_rdata)));
    assert_wait_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_n) |-> (!en_n && !rd_n));
    assert_done_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_n) |-> done_irq);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
endmodule

// File: rtl/hostxfer_port.sv
module hostxfer_port #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    localparam int W     = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_n,
    input  logic [W-1:0]      host_wdata,
    input  logic              host_rd_n,
    output logic [W-1:0]      host_rdata,
    output logic              xfer_en_n,
    output logic              wait_n,
    input  logic              cmd_pop,
    output logic [W-1:0]      cmd_data,
    output logic [CW-1:0]     cmd_count,
    output logic              cmd_empty,
    output logic              cmd_ovf,
    output logic              cmd_irq,
    input  logic              cpu_start,
    input  logic [LEN_W-1:0]  cpu_len,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              done_irq,
    output logic              ram_rd,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [W-1:0]      ram_rdata,
    input  logic              ram_ack
);
    logic wr_fall;

    hxp_fall_det u_wr_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n), .fall(wr_fall)
    );

    hxp_cmd_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(wr_fall), .push_data(host_wdata), .pop(cmd_pop),
        .head(cmd_data), .count(cmd_count), .empty(cmd_empty),
        .ovf(cmd_ovf), .irq(cmd_irq)
    );

    hxp_xfer_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .W(W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .start(cpu_start), .len_in(cpu_len), .addr_in(cpu_addr),
        .rd_n(host_rd_n), .rd_data(host_rdata), .en_n(xfer_en_n),
        .wait_n(wait_n), .done_irq(done_irq),
        .ram_rd(ram_rd), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .ram_ack(ram_ack)
    );

    assert_cmd_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |=> !cmd_irq);
    assert_irq_raises_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_irq && !$past(cmd_pop)) |-> (cmd_count == $past(cmd_count) + 1'b1));
endmodule

// File: tb/test_hostxfer_port.sv
module test_hostxfer_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr_n, host_rd_n, cmd_pop, cpu_start, ram_ack;
    logic [7:0]  host_wdata, host_rdata, cmd_data, ram_rdata;
    logic [3:0]  cmd_count;
    logic        xfer_en_n, wait_n, cmd_empty, cmd_ovf, cmd_irq, done_irq, ram_rd;
    logic [15:0] cpu_len, cpu_addr, ram_addr;
    int          errors = 0, checks = 0, ram_lat = 0, lat_cnt = 0;

    always #4 clk = ~clk;

    hostxfer_port i_hostxfer_port (.*);

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ (a[15:8] + 8'h47);
    endfunction

    // buffer RAM model with selectable latency
    always @(posedge clk) begin
        if (!ram_rd || ram_ack) begin
            ram_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (lat_cnt == ram_lat) begin
            ram_ack   <= 1'b1;
            ram_rdata <= mem_byte(ram_addr);
        end else begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] b, input logic accept);
        @(negedge clk); host_wr_n = 1'b0; host_wdata = b;
        @(negedge clk);
        chk(accept ? "R3 irq on write" : "R4 no irq when full", cmd_irq, accept);
        host_wr_n = 1'b1;
        @(negedge clk);
        chk("R3 irq one cycle", cmd_irq, 1'b0);
    endtask

    task automatic pop_one();
        @(negedge clk); cmd_pop = 1'b1;
        @(negedge clk); cmd_pop = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1 count", cmd_count, 0);
        chk("R1 empty", cmd_empty, 1);
        chk("R1 ovf", cmd_ovf, 0);
        chk("R1 cmd_irq", cmd_irq, 0);
        chk("R1 done_irq", done_irq, 0);
        chk("R1 xfer_en_n", xfer_en_n, 1);
        chk("R1 wait_n", wait_n, 1);
        chk("R1 ram_rd", ram_rd, 0);
    endtask

    task automatic t_cmd_order();
        host_write(8'hA1, 1); host_write(8'h02, 1); host_write(8'hFF, 1);
        chk("R2 count three", cmd_count, 3);
        chk("R2 head oldest", cmd_data, 8'hA1);
        pop_one(); chk("R5 second byte", cmd_data, 8'h02);
        pop_one(); chk("R5 third byte", cmd_data, 8'hFF);
        pop_one(); chk("R5 drained", cmd_empty, 1);
        pop_one(); chk("R5 pop empty count", cmd_count, 0);
        host_write(8'h3C, 1);
        chk("R5 pop empty no effect", cmd_data, 8'h3C);
        pop_one();
    endtask

    task automatic t_cmd_overflow();
        for (int i = 0; i < 8; i++) host_write(8'h10 + 8'(i), 1);
        chk("R2 full count", cmd_count, 8);
        chk("R4 ovf before", cmd_ovf, 0);
        host_write(8'hEE, 0);
        chk("R4 count kept", cmd_count, 8);
        chk("R4 ovf set", cmd_ovf, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R4 contents kept", cmd_data, 8'h10 + 8'(i));
            pop_one();
        end
        chk("R4 ovf sticky", cmd_ovf, 1);
        chk("R5 empty after drain", cmd_empty, 1);
    endtask

    task automatic t_xfer(input logic [15:0] a0, input int n, input int gap, input int inject);
        logic [15:0] a = a0;
        @(negedge clk); cpu_start = 1'b1; cpu_addr = a0; cpu_len = 16'(n);
        @(negedge clk); cpu_start = 1'b0;
        chk("R6 enable low", xfer_en_n, 0);
        chk("R6 ram read", ram_rd, 1);
        chk("R6 ram addr", ram_addr, a0);
        for (int i = 0; i < n; i++) begin
            if (i == inject) begin
                cpu_start = 1'b1; cpu_addr = 16'h9000; cpu_len = 16'd40;
                @(negedge clk); cpu_start = 1'b0;
            end
            repeat (gap) @(negedge clk);
            host_rd_n = 1'b0;
            @(negedge clk);
            chk("R8 wait at strobe", wait_n, (gap >= 6) ? 1'b1 : 1'b0);
            while (!wait_n) @(negedge clk);
            chk("R7 byte", host_rdata, mem_byte(a));
            chk("R6 enable held", xfer_en_n, 0);
            host_rd_n = 1'b1;
            a = a + 16'd1;
            @(negedge clk);
            if (i == n - 1) begin
                chk("R9 enable high", xfer_en_n, 1);
                chk("R9 done pulse", done_irq, 1);
            end else begin
                chk("R9 no early done", done_irq, 0);
            end
        end
        @(negedge clk);
        chk("R9 done one cycle", done_irq, 0);
        chk("R10 stays idle", xfer_en_n, 1);
    endtask

    task automatic t_zero_len();
        @(negedge clk); cpu_start = 1'b1; cpu_len = 16'd0; cpu_addr = 16'h0040;
        @(negedge clk); cpu_start = 1'b0;
        chk("R10 zero len done", done_irq, 1);
        chk("R10 zero len idle", xfer_en_n, 1);
        @(negedge clk);
        chk("R10 zero len pulse", done_irq, 0);
        chk("R10 no ram read", ram_rd, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_wr_n = 1'b1; host_rd_n = 1'b1; cmd_pop = 1'b0;
        cpu_start = 1'b0; cpu_len = '0; cpu_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_cmd_order();
        t_cmd_overflow();
        ram_lat = 0; t_xfer(16'h0120, 5, 0, -1);
        ram_lat = 3; t_xfer(16'hFFFE, 4, 0, -1);
        ram_lat = 0; t_xfer(16'h7000, 3, 6, -1);
        ram_lat = 1; t_xfer(16'h0100, 3, 0, 1);
        t_zero_len();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule